// File: doc/BRIEF.md
# L1 Invalidation Walk Sequencer

This block serves acquire-type memory synchronisation requests coming from a compute unit. On an accepted acquire it sweeps every line index of the L1 data cache and sends one invalidate request per index to the cache controller. It keeps a count of the invalidates that have been sent but not yet acknowledged. Once the sweep has finished and that count is back at zero, it returns a completion carrying the identifier of the acquire.

Only one sweep can be active at a time. An acquire that arrives while a sweep is active is not queued. It gets an explicit retry status in the same cycle, and the sweep in progress continues unchanged. A release-type synchronisation request is not supported and is flagged as an error. An acknowledgement that arrives when nothing is outstanding is also flagged as an error and has no effect on the count.

Top module: `l1_inv_walker`

## Requirements
- R1: An acquire (`sync_valid`=1, `sync_acquire`=1) presented while the block is idle raises `sync_accept` in the same cycle, and `busy` is high from the next cycle on.
- R2: A release-type request (`sync_valid`=1, `sync_acquire`=0) raises `sync_err` in the same cycle, does not raise `sync_accept`, and starts no sweep (`busy` stays low).
- R3: An acquire presented while `busy` is high raises `sync_retry` and not `sync_accept`. The active sweep keeps its identifier and its index sequence.
- R4: A sweep over N lines issues exactly N invalidates with `inv_index` values 0, 1, …, N-1 in ascending order, at most one per cycle. An invalidate is issued in a cycle where `inv_valid` and `inv_ready` are both high.
- R5: While `inv_valid` is high and `inv_ready` is low, `inv_valid` stays high and `inv_index` stays unchanged in the next cycle.
- R6: `done_valid` rises only after all N invalidates have been issued and all N have been acknowledged through `inv_ack`. `done_id` then equals the identifier of the accepted acquire.
- R7: `done_valid` and `done_id` are held until `done_ready` is high. `busy` stays high until that cycle and is low in the cycle after it.
- R8: An `inv_ack` pulse that arrives while no invalidate is outstanding raises `ack_err` in the same cycle and does not change the outstanding count. A valid acknowledgement keeps `ack_err` low.
- R9: In a cycle where an invalidate is issued and an acknowledgement arrives together, the outstanding count stays unchanged, so completion still waits for every acknowledgement.
- R10: An acquire with `line_count`=0 issues no invalidate and completes directly with `done_valid`.
- R11: During and right after reset, `busy`, `inv_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_valid | input | 1 | Synchronisation request present |
| sync_acquire | input | 1 | 1 = acquire, 0 = release (unsupported) |
| sync_id | input | ID_W | Request identifier |
| line_count | input | CNT_W | Number of L1 lines to sweep, sampled when an acquire is accepted |
| sync_accept | output | 1 | Acquire accepted this cycle |
| sync_retry | output | 1 | Acquire refused because a sweep is active; requester retries later |
| sync_err | output | 1 | Release-type request flagged as unsupported |
| inv_valid | output | 1 | Invalidate request valid |
| inv_index | output | IDX_W | Line index to invalidate |
| inv_ready | input | 1 | Cache controller takes the invalidate |
| inv_ack | input | 1 | One invalidate completed |
| ack_err | output | 1 | Acknowledgement arrived with nothing outstanding |
| busy | output | 1 | A sweep is active or its completion is not yet taken |
| done_valid | output | 1 | Acquire completion valid |
| done_id | output | ID_W | Identifier of the completed acquire |
| done_ready | input | 1 | Requester takes the completion |

## Verification
Sweeps of one line, of zero lines and of the full maximum line count are driven with the cache always ready and acknowledging promptly. These runs separate the end-of-sweep boundaries from the general case. Random sweeps of varied length then throttle `inv_ready`, delay acknowledgements and stall `done_ready`. This exposes index slips under back-pressure, an early completion, and miscounting when an issue and an acknowledgement fall in the same cycle. Directed stimulus covers the remaining cases: a release request, a stray acknowledgement while idle, and an acquire injected in the middle of a sweep, which separate the error and retry paths from a normal start.

// File: rtl/inv_walk_pkg.sv
`timescale 1ns/1ps
package inv_walk_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_WALK  = 2'd1,
        WS_DRAIN = 2'd2,
        WS_RESP  = 2'd3
    } walk_state_e;

    // Next state of the sweep controller.
    function automatic walk_state_e walk_step(
        input walk_state_e cur,
        input logic        accept,
        input logic        lines_zero,
        input logic        issue_last,
        input logic        drained,
        input logic        resp_taken
    );
        walk_state_e nxt;
        nxt = cur;
        unique case (cur)
            WS_IDLE:  if (accept)     nxt = lines_zero ? WS_RESP : WS_WALK;
            WS_WALK:  if (issue_last) nxt = WS_DRAIN;
            WS_DRAIN: if (drained)    nxt = WS_RESP;
            WS_RESP:  if (resp_taken) nxt = WS_IDLE;
            default:                  nxt = WS_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/inv_index_gen.sv
`timescale 1ns/1ps
module inv_index_gen #(
    parameter int MAX_LINES = 256,
    localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
    localparam int CNT_W = $clog2(MAX_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] line_count,
    input  logic             walking,
    input  logic             fire,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            count_q <= '0;
        end else if (start) begin
            idx_q   <= '0;
            count_q <= line_count;
        end else if (fire) begin
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    assign idx  = idx_q;
    assign last = (CNT_W'(idx_q) == (count_q - CNT_W'(1)));

    // R4: an index on the port never reaches the latched line count
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (rst)
        walking |-> (CNT_W'(idx_q) < count_q));

    // R4: the index moves by exactly one per accepted invalidate
    p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
        (walking && fire && !last) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/inv_pend_counter.sv
`timescale 1ns/1ps
module inv_pend_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             ack,
    output logic             zero,
    output logic             ack_err
);
    logic [CNT_W-1:0] pend_q;
    logic             dec;

    assign dec     = ack && (pend_q != '0);
    assign ack_err = ack && (pend_q == '0);
    assign zero    = (pend_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   pend_q <= pend_q + CNT_W'(1);
                2'b01:   pend_q <= pend_q - CNT_W'(1);
                default: pend_q <= pend_q;
            endcase
        end
    end

    // R8: a stray acknowledgement leaves the count at zero
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0 && ack && !inc) |=> (pend_q == '0));

    // R9: a simultaneous issue and valid acknowledgement leaves the count unchanged
    p_simul_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && ack && pend_q != '0) |=> $stable(pend_q));

    // R9: the count never wraps past its maximum
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && !ack) |=> (pend_q != '0));
endmodule

// File: rtl/inv_walk_ctrl.sv
`timescale 1ns/1ps
module inv_walk_ctrl
    import inv_walk_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_valid,
    input  logic            sync_acquire,
    input  logic [ID_W-1:0] sync_id,
    input  logic            lines_zero,
    input  logic            last,
    input  logic            inv_ready,
    input  logic            pend_zero,
    input  logic            done_ready,
    output logic            sync_accept,
    output logic            sync_retry,
    output logic            sync_err,
    output logic            start,
    output logic            walking,
    output logic            busy,
    output logic            done_valid,
    output logic [ID_W-1:0] done_id
);
    walk_state_e     state_q, state_d;
    logic [ID_W-1:0] id_q;

    always_comb begin
        sync_accept = sync_valid && sync_acquire && (state_q == WS_IDLE);
        sync_retry  = sync_valid && sync_acquire && (state_q != WS_IDLE);
        sync_err    = sync_valid && !sync_acquire;
        start       = sync_accept;
        walking     = (state_q == WS_WALK);
        busy        = (state_q != WS_IDLE);
        done_valid  = (state_q == WS_RESP);
        state_d     = walk_step(state_q, sync_accept, lines_zero,
                                walking && inv_ready && last,
                                pend_zero, done_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (sync_accept) id_q <= sync_id;
        end
    end

    assign done_id = id_q;

    // R3: the stored identifier does not change while a sweep is active
    p_id_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(id_q));

    // R3: a refused acquire does not end the active sweep
    p_retry_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (sync_retry && !done_valid) |=> busy);

    // R2: a release request never starts a sweep
    p_release_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_err && !busy) |=> !busy);

    // R6: completion is only raised with nothing outstanding
    p_done_drained_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> pend_zero);
endmodule

// File: rtl/l1_inv_walker.sv
`timescale 1ns/1ps
module l1_inv_walker #(
    parameter int MAX_LINES = 256,
    parameter int ID_W      = 8,
    localparam int IDX_W = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
    localparam int CNT_W = $clog2(MAX_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_valid,
    input  logic             sync_acquire,
    input  logic [ID_W-1:0]  sync_id,
    input  logic [CNT_W-1:0] line_count,
    output logic             sync_accept,
    output logic             sync_retry,
    output logic             sync_err,
    output logic             inv_valid,
    output logic [IDX_W-1:0] inv_index,
    input  logic             inv_ready,
    input  logic             inv_ack,
    output logic             ack_err,
    output logic             busy,
    output logic             done_valid,
    output logic [ID_W-1:0]  done_id,
    input  logic             done_ready
);
    logic start, last, pend_zero, fire;

    assign fire = inv_valid && inv_ready;

    inv_walk_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .sync_valid  (sync_valid),
        .sync_acquire(sync_acquire),
        .sync_id     (sync_id),
        .lines_zero  (line_count == '0),
        .last        (last),
        .inv_ready   (inv_ready),
        .pend_zero   (pend_zero),
        .done_ready  (done_ready),
        .sync_accept (sync_accept),
        .sync_retry  (sync_retry),
        .sync_err    (sync_err),
        .start       (start),
        .walking     (inv_valid),
        .busy        (busy),
        .done_valid  (done_valid),
        .done_id     (done_id)
    );

    inv_index_gen #(.MAX_LINES(MAX_LINES)) u_idx (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .line_count(line_count),
        .walking   (inv_valid),
        .fire      (fire),
        .idx       (inv_index),
        .last      (last)
    );

    inv_pend_counter #(.CNT_W(CNT_W)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .inc    (fire),
        .ack    (inv_ack),
        .zero   (pend_zero),
        .ack_err(ack_err)
    );

    // R5: a stalled invalidate is held with the same index
    p_inv_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_index)));

    // R7: the completion and its identifier are held until taken
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_ready) |=> (done_valid && $stable(done_id)));

    // R7: taking the completion returns the block to idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_ready) |=> !busy);

    // R1: an accepted acquire makes the block busy in the next cycle
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        sync_accept |=> busy);
endmodule

// File: tb/tb_l1_inv_walker.sv
`timescale 1ns/1ps
module tb_l1_inv_walker;
    localparam int MAX_LINES = 256;
    localparam int ID_W      = 8;
    localparam int IDX_W     = $clog2(MAX_LINES);
    localparam int CNT_W     = $clog2(MAX_LINES + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst, sync_valid, sync_acquire, inv_ready, inv_ack, done_ready;
    logic [ID_W-1:0]  sync_id;
    logic [CNT_W-1:0] line_count;
    logic             sync_accept, sync_retry, sync_err, inv_valid, ack_err, busy, done_valid;
    logic [IDX_W-1:0] inv_index;
    logic [ID_W-1:0]  done_id;

    int errors = 0;
    int checks = 0;
    int simul  = 0;
    int cycles = 0;

    l1_inv_walker #(.MAX_LINES(MAX_LINES), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .sync_valid(sync_valid), .sync_acquire(sync_acquire),
        .sync_id(sync_id), .line_count(line_count), .sync_accept(sync_accept),
        .sync_retry(sync_retry), .sync_err(sync_err), .inv_valid(inv_valid),
        .inv_index(inv_index), .inv_ready(inv_ready), .inv_ack(inv_ack),
        .ack_err(ack_err), .busy(busy), .done_valid(done_valid), .done_id(done_id),
        .done_ready(done_ready)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full acquire sweep, called at a negedge with the block idle.
    task automatic run_walk(input int id, input int n, input int rdy_pct,
                            input int ack_pct, input bit poke);
        int  issued = 0;
        int  acked  = 0;
        int  outst  = 0;
        int  cyc    = 0;
        bit  fin    = 0;
        bit  seen   = 0;
        bit  stall  = 0;
        int  sidx   = 0;
        sync_valid = 1'b1; sync_acquire = 1'b1;
        sync_id = ID_W'(id); line_count = CNT_W'(n);
        #1;
        chk("R1", "accept when idle", int'(sync_accept), 1);
        chk("R3", "no retry when idle", int'(sync_retry), 0);
        next_cycle();
        sync_valid = 1'b0;
        chk("R1", "busy after accept", int'(busy), 1);
        while (!fin && cyc < 20000) begin
            cyc++;
            inv_ready  = ($urandom % 100) < rdy_pct;
            inv_ack    = (outst > 0) && (($urandom % 100) < ack_pct);
            done_ready = ($urandom % 100) < 60;
            if (poke && cyc == 2) begin
                sync_valid = 1'b1; sync_acquire = 1'b1; sync_id = ID_W'(id ^ 8'hFF);
            end else begin
                sync_valid = 1'b0;
            end
            #1;
            if (sync_valid) begin
                chk("R3", "retry while busy", int'(sync_retry), 1);
                chk("R3", "no accept while busy", int'(sync_accept), 0);
            end
            if (stall) begin
                chk("R5", "stalled valid held", int'(inv_valid), 1);
                chk("R5", "stalled index held", int'(inv_index), sidx);
            end
            if (inv_valid) chk("R4", "index order", int'(inv_index), issued);
            if (inv_ack)   chk("R8", "no ack_err on valid ack", int'(ack_err), 0);
            if (done_valid) begin
                if (!seen) begin
                    chk("R6", "acks before done", acked, n);
                    chk("R6", "issues before done", issued, n);
                    chk("R6", "done id", int'(done_id), id & 8'hFF);
                    seen = 1;
                end
                chk("R7", "busy during done", int'(busy), 1);
                if (done_ready) fin = 1;
            end else if (seen) begin
                chk("R7", "done held until taken", 0, 1);
            end
            stall = inv_valid && !inv_ready;
            sidx  = int'(inv_index);
            if (inv_valid && inv_ready) begin
                issued++; outst++;
                if (inv_ack) simul++;
            end
            if (inv_ack) begin
                acked++; outst--;
            end
            next_cycle();
        end
        inv_ready = 1'b0; inv_ack = 1'b0; done_ready = 1'b0; sync_valid = 1'b0;
        #1;
        chk("R7", "idle after completion taken", int'(busy), 0);
        chk("R6", "sweep completed", int'(fin), 1);
        if (n == 0) chk("R10", "no invalidates for zero lines", issued, 0);
        else        chk("R4", "invalidate count", issued, n);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; sync_valid = 1'b0; sync_acquire = 1'b0; sync_id = '0;
        line_count = '0; inv_ready = 1'b0; inv_ack = 1'b0; done_ready = 1'b0;
        @(negedge clk);
        repeat (3) next_cycle();
        chk("R11", "busy in reset", int'(busy), 0);
        chk("R11", "inv_valid in reset", int'(inv_valid), 0);
        chk("R11", "done_valid in reset", int'(done_valid), 0);
        rst = 1'b0;
        next_cycle();
        chk("R11", "busy after reset", int'(busy), 0);

        // R2: release request
        sync_valid = 1'b1; sync_acquire = 1'b0; sync_id = 8'h44; line_count = 9'd4;
        #1;
        chk("R2", "release flagged", int'(sync_err), 1);
        chk("R2", "release not accepted", int'(sync_accept), 0);
        next_cycle();
        sync_valid = 1'b0;
        chk("R2", "no sweep after release", int'(busy), 0);
        chk("R2", "no invalidate after release", int'(inv_valid), 0);

        // R8: stray acknowledgement while idle
        inv_ack = 1'b1;
        #1;
        chk("R8", "stray ack flagged", int'(ack_err), 1);
        next_cycle();
        inv_ack = 1'b0;
        run_walk(8'h05, 3, 100, 100, 1'b0);

        // directed boundaries
        run_walk(8'h11, 1, 100, 100, 1'b1);
        run_walk(8'h22, 0, 100, 100, 1'b1);
        run_walk(8'h33, MAX_LINES, 100, 100, 1'b1);

        // random sweeps with back-pressure and late acknowledgements
        for (int k = 0; k < 12; k++) begin
            run_walk(int'($urandom % 256), int'($urandom % 40) + 1,
                     30 + int'($urandom % 71), 20 + int'($urandom % 81), k[0]);
        end

        chk("R9", "issue and ack together were seen", int'(simul > 0), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule